// File: doc/BRIEF.md
# Precise Exception Entry Controller

This block decides, every cycle, whether a five-stage pipeline must enter an exception handler. Two fault sources feed it. The decode stage can report an instruction with an undefined opcode, and the execute stage can report an arithmetic overflow. Each report comes with the address of the instruction that raised it. When either fault is present, the controller takes the exception in that cycle. It flushes the faulting instruction and every younger instruction. Instructions older than the fault are left alone, so they finish normally. It also steers fetch to the handler.

On the following clock edge it records two values. The first is a return address, equal to the faulting instruction's address plus four. The second is a one-bit cause code. If both stages fault in the same cycle, the instruction in execute is the older one, so its overflow is the exception that is taken.

A parameter selects how the handler address is formed. The controller can send every cause to one fixed entry point. It can also index a vector table, in which entries are spaced evenly by cause number.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the saved return address and the cause output are both zero. With no fault present, no flush and no redirect is asserted.
- R2: An overflow in execute is taken in the same cycle. On the next clock edge the cause becomes 1 and the saved address becomes the execute address plus 4, computed modulo 2^32.
- R3: An undefined opcode in decode, with no overflow present, is taken in the same cycle. On the next clock edge the cause becomes 0 and the saved address becomes the decode address plus 4.
- R4: When both faults are present in one cycle, the overflow wins. The cause becomes 1 and the saved address is built from the execute address.
- R5: A decode fault asserts the IF/ID flush and the ID/EX flush but not the EX/MEM flush. An overflow asserts all three flushes, and the EX/MEM flush cancels the faulting instruction's register write.
- R6: In single-handler mode (VECTORED=0), the redirect address is 0x80000180 for either cause.
- R7: In vectored mode (VECTORED=1), the redirect address is 0xC0000000 plus 0x20 times the cause. That gives 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R8: In any cycle without a fault, the saved address and the cause keep their values.
- R9: The redirect valid output is high exactly in the cycles where at least one fault input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_undef | input | 1 | Decode stage holds an undefined opcode |
| id_pc | input | 32 | Address of the instruction in decode |
| ex_ovf | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc | input | 32 | Address of the instruction in execute |
| flush_if_id | output | 1 | Clear the IF/ID stage register |
| flush_id_ex | output | 1 | Zero the control fields entering ID/EX |
| flush_ex_mem | output | 1 | Zero the control fields entering EX/MEM, which cancels the write |
| redirect_valid | output | 1 | Fetch must load the redirect address |
| redirect_pc | output | 32 | Handler entry address |
| epc | output | 32 | Saved return address (faulting address + 4) |
| cause | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
Some properties are checked by assertions on every cycle:
- the saved address is one word past the selected fault;
- the saved state holds when no fault is present;
- a flush of EX/MEM happens only with an overflow, and the two upper flushes always accompany a redirect;
- the cause after a double fault is overflow;
- the handler address matches the mode in use.

Other properties can only be shown by the bench scenarios:
- wrap-around of the return address at the top of the address space;
- the exact vector spacing;
- the reset values;
- the retained state after a long run of clean cycles, for all four input combinations.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // one-bit cause code; values are architectural
  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            id_undef,
  input  logic [XLEN-1:0] id_pc,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc,
  output logic            take,
  output logic            from_ex,
  output cause_e          sel_cause,
  output logic [XLEN-1:0] sel_pc
);
  // execute holds the older instruction, so its fault wins
  always_comb begin
    take      = id_undef | ex_ovf;
    from_ex   = ex_ovf;
    sel_cause = CAUSE_UNDEF;
    sel_pc    = id_pc;
    if (ex_ovf) begin
      sel_cause = CAUSE_OVF;
      sel_pc    = ex_pc;
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter bit              VECTORED   = 1'b0,
  parameter logic [XLEN-1:0] FIXED_ADDR = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  cause_e          cause_in,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] cause_idx;
  assign cause_idx = {{(XLEN-1){1'b0}}, cause_in};

  generate
    if (VECTORED) begin : g_vec
      assign target = VEC_BASE + cause_idx * VEC_STRIDE;
    end else begin : g_fixed
      logic unused_cause;
      assign unused_cause = ^cause_idx;
      assign target = FIXED_ADDR;
    end
  endgenerate
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  cause_e          cause_in,
  input  logic [XLEN-1:0] pc_in,
  output logic [XLEN-1:0] epc_q,
  output cause_e          cause_q
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= CAUSE_UNDEF;
    end else if (take) begin
      epc_q   <= pc_in + PC_STEP;
      cause_q <= cause_in;
    end
  end

  // R2 / R3: saved address is one word past the chosen fault
  a_r2_epc_step: assert property (@(posedge clk) disable iff (rst)
    take |=> (epc_q == $past(pc_in) + PC_STEP) && (cause_q == $past(cause_in)));

  // R8: no fault, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(epc_q) && $stable(cause_q));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter bit              VECTORED   = 1'b0,
  parameter logic [XLEN-1:0] FIXED_ADDR = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            id_undef,
  input  logic [XLEN-1:0] id_pc,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc,
  output logic            flush_if_id,
  output logic            flush_id_ex,
  output logic            flush_ex_mem,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic            cause
);
  logic            take;
  logic            from_ex;
  cause_e          sel_cause;
  logic [XLEN-1:0] sel_pc;
  cause_e          cause_q;

  exc_arbiter #(.XLEN(XLEN)) u_arb (
    .id_undef (id_undef),
    .id_pc    (id_pc),
    .ex_ovf   (ex_ovf),
    .ex_pc    (ex_pc),
    .take     (take),
    .from_ex  (from_ex),
    .sel_cause(sel_cause),
    .sel_pc   (sel_pc)
  );

  exc_vector #(
    .XLEN(XLEN), .VECTORED(VECTORED), .FIXED_ADDR(FIXED_ADDR),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_vec (
    .cause_in(sel_cause),
    .target  (redirect_pc)
  );

  exc_state #(.XLEN(XLEN)) u_state (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .cause_in(sel_cause),
    .pc_in   (sel_pc),
    .epc_q   (epc),
    .cause_q (cause_q)
  );

  // faulting instruction and everything younger is squashed
  assign redirect_valid = take;
  assign flush_if_id    = take;
  assign flush_id_ex    = take;
  assign flush_ex_mem   = take & from_ex;
  assign cause          = cause_q;

  // R5: the EX/MEM flush is only ever caused by an overflow
  a_r5_exmem_only_ovf: assert property (@(posedge clk) disable iff (rst)
    flush_ex_mem |-> ex_ovf);

  // R5: every redirect clears both upper stage registers
  a_r5_upper_flush: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> flush_if_id && flush_id_ex);

  // R4: a double fault records the overflow
  a_r4_ovf_wins: assert property (@(posedge clk) disable iff (rst)
    (ex_ovf && id_undef) |=> cause);

  // R9: no redirect without a fault input
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    !(id_undef || ex_ovf) |-> !redirect_valid && !flush_ex_mem);

  generate
    if (VECTORED) begin : g_chk_vec
      // R7: overflow entry sits one stride above the base
      a_r7_ovf_slot: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && ex_ovf) |-> redirect_pc == VEC_BASE + VEC_STRIDE);
    end else begin : g_chk_fixed
      // R6: one entry point for all causes
      a_r6_fixed_entry: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> redirect_pc == FIXED_ADDR);
    end
  endgenerate
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        id_undef, ex_ovf;
  logic [31:0] id_pc, ex_pc;

  logic        f_fd, f_dx, f_xm, rv;
  logic [31:0] rpc, epc;
  logic        cause;
  logic        v_fd, v_dx, v_xm, v_rv;
  logic [31:0] v_rpc, v_epc;
  logic        v_cause;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl #(.VECTORED(1'b0)) dut (
    .clk(clk), .rst(rst), .id_undef(id_undef), .id_pc(id_pc),
    .ex_ovf(ex_ovf), .ex_pc(ex_pc), .flush_if_id(f_fd), .flush_id_ex(f_dx),
    .flush_ex_mem(f_xm), .redirect_valid(rv), .redirect_pc(rpc),
    .epc(epc), .cause(cause));

  exc_entry_ctrl #(.VECTORED(1'b1)) dut_vec (
    .clk(clk), .rst(rst), .id_undef(id_undef), .id_pc(id_pc),
    .ex_ovf(ex_ovf), .ex_pc(ex_pc), .flush_if_id(v_fd), .flush_id_ex(v_dx),
    .flush_ex_mem(v_xm), .redirect_valid(v_rv), .redirect_pc(v_rpc),
    .epc(v_epc), .cause(v_cause));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp_epc;
    logic        exp_cause;
    rst = 1'b1; id_undef = 1'b0; ex_ovf = 1'b0; id_pc = '0; ex_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #2;
    // R1: reset state
    chk("R1 epc", epc, 32'h0);
    chk("R1 cause", {31'b0, cause}, 32'h0);
    chk("R1 vec epc", v_epc, 32'h0);
    chk("R1 no redirect", {31'b0, rv}, 32'h0);
    chk("R1 no flush", {29'b0, f_fd, f_dx, f_xm}, 32'h0);
    exp_epc = '0;
    exp_cause = 1'b0;

    for (int pat = 0; pat < 4; pat++) begin
      for (int i = 0; i < 6; i++) begin
        logic any;
        logic [31:0] exp_rv_vec;
        @(negedge clk);
        id_undef = pat[0];
        ex_ovf   = pat[1];
        ex_pc    = (i == 5) ? 32'hFFFF_FFFC : 32'h4C + 32'(i) * 32'h104;
        id_pc    = ex_pc + 32'd4;
        any      = id_undef | ex_ovf;
        #2;
        // R9: redirect follows the fault inputs
        chk("R9 redirect_valid", {31'b0, rv}, {31'b0, any});
        // R5: flush pattern depends on which stage faulted
        chk("R5 flush if_id", {31'b0, f_fd}, {31'b0, any});
        chk("R5 flush id_ex", {31'b0, f_dx}, {31'b0, any});
        chk("R5 flush ex_mem", {31'b0, f_xm}, {31'b0, ex_ovf});
        if (any) begin
          // R6: fixed entry
          chk("R6 fixed handler", rpc, 32'h8000_0180);
          // R7: base + 0x20 * cause
          exp_rv_vec = 32'hC000_0000 + (ex_ovf ? 32'h20 : 32'h0);
          chk("R7 vector handler", v_rpc, exp_rv_vec);
        end
        if (ex_ovf) begin
          exp_epc = ex_pc + 32'd4;
          exp_cause = 1'b1;
        end else if (id_undef) begin
          exp_epc = id_pc + 32'd4;
          exp_cause = 1'b0;
        end
        @(posedge clk);
        #2;
        if (pat == 3)      begin chk("R4 epc both", epc, exp_epc); chk("R4 cause both", {31'b0, cause}, {31'b0, exp_cause}); end
        else if (pat == 2) begin chk("R2 epc ovf", epc, exp_epc);  chk("R2 cause ovf", {31'b0, cause}, {31'b0, exp_cause}); end
        else if (pat == 1) begin chk("R3 epc undef", epc, exp_epc); chk("R3 cause undef", {31'b0, cause}, {31'b0, exp_cause}); end
        else               begin chk("R8 epc hold", epc, exp_epc); chk("R8 cause hold", {31'b0, cause}, {31'b0, exp_cause}); end
        chk("R2 vec epc mirror", v_epc, exp_epc);
        // quiet cycle between faults: state must hold (R8)
        @(negedge clk);
        id_undef = 1'b0; ex_ovf = 1'b0;
        id_pc = 32'h1234_5678; ex_pc = 32'h0BAD_0000;
        @(posedge clk);
        #2;
        chk("R8 hold after quiet", epc, exp_epc);
        chk("R8 cause after quiet", {31'b0, cause}, {31'b0, exp_cause});
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule